// File: doc/BRIEF.md
# Floating-Point Control Word with Mode Resolution

This block keeps the floating-point control and status word of a core. The word holds sticky exception flags, a dynamic rounding mode and a two-bit accuracy mode that sits in bits no other field uses. Software reaches the word through CSR accesses that write it, set bits in it or clear bits in it. Each access returns the value the word held before the access.

For every FP operation that issues, the block works out which rounding mode applies: the one encoded in the instruction, or the dynamic one held in the word. It also reports the current accuracy mode. It checks that mode against a per-operation-class support mask fixed at build time. When the dynamic rounding mode is reserved, or when the accuracy mode is not supported for that class, it raises a single illegal-instruction signal so that the trap path can take over. Exception flags that a legal operation reports are ORed into the sticky flag field.

Top module: `fpu_ctl_status`

## Requirements
- R1: After reset the word reads as zero: no flags, rounding mode 000, accuracy mode 00.
- R2: A write (op code 0) stores bits [9:0]: flags at [4:0], rounding mode at [7:5], accuracy mode at [9:8]. Bits [31:10] always read zero. `csr_rdata` shows the word as it was before the access, and the new value is visible from the next cycle.
- R3: Op code 1 sets the word bits that are 1 in `csr_wdata`. Op code 2 clears the word bits that are 1 in `csr_wdata`. Op code 3 only reads.
- R4: When `op_rm` is 111, `eff_rm` equals the stored rounding mode. Any other `op_rm` value passes through unchanged to `eff_rm`.
- R5: An issued operation with `op_rm` = 111 while the stored rounding mode is 101, 110 or 111 raises `op_illegal`. A static `op_rm` never raises it on rounding grounds.
- R6: `eff_acc` shows the stored accuracy mode. `op_illegal` rises when bit `mode` of the class's 4-bit support mask is 0. Mode 00 is always supported. Default masks are class 0 = 1111, class 1 = 0011, class 2 = 0101, class 3 = 0001.
- R7: A legal issued operation ORs `op_flags` into word bits [4:0], and the result is visible in the next cycle.
- R8: An operation that raises `op_illegal` leaves the word unchanged.
- R9: A write, set or clear in the same cycle as a flag accumulation wins: the word takes the CSR result only.
- R10: With `op_valid` low, `op_illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_en | input | 1 | CSR access this cycle |
| csr_op | input | 2 | 0 write, 1 set, 2 clear, 3 read |
| csr_wdata | input | 32 | Write or mask data |
| csr_rdata | output | 32 | Word value before the access |
| op_valid | input | 1 | FP operation issued this cycle |
| op_class | input | 2 | Operation class index |
| op_rm | input | 3 | Instruction rounding field |
| op_flags | input | 5 | Exception flags raised by the operation |
| eff_rm | output | 3 | Resolved rounding mode |
| eff_acc | output | 2 | Accuracy mode in force |
| op_illegal | output | 1 | Illegal-instruction request |

## Verification
Rounding resolution is tried with static fields against several stored dynamic values. This separates pass-through from dynamic lookup. Every reserved dynamic value is then paired with both a dynamic and a static request, which shows that only dynamic use traps. The full grid of four accuracy modes against four classes tells a correct mask lookup apart from swapped class or mode indexing and from a mode-0 leak. Flag accumulation runs alone, against an illegal operation, and against a concurrent write or set, which exposes the suppression and priority ordering.

// File: rtl/fpctl_pkg.sv
// Shared field layout and CSR op codes for the FP control word.
// Assumes the word is 32 bits wide with the live fields packed at the bottom.
package fpctl_pkg;
    localparam int WORD_W  = 32;
    localparam int FLAG_W  = 5;
    localparam int RM_W    = 3;
    localparam int ACC_W   = 2;
    localparam int RM_LSB  = FLAG_W;
    localparam int ACC_LSB = FLAG_W + RM_W;
    localparam int LIVE_W  = FLAG_W + RM_W + ACC_W;
    localparam int MODES   = 1 << ACC_W;

    localparam logic [RM_W-1:0] RM_DYNAMIC = 3'b111;

    typedef enum logic [1:0] {
        CSR_WRITE = 2'd0,
        CSR_SET   = 2'd1,
        CSR_CLEAR = 2'd2,
        CSR_READ  = 2'd3
    } csr_op_e;
endpackage

// File: rtl/fpctl_state_reg.sv
// Holds the live bits of the control word and applies CSR updates or
// flag accumulation. Assumes a CSR modify wins over accumulation.
module fpctl_state_reg
    import fpctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_en,
    input  logic [1:0]        csr_op,
    input  logic [LIVE_W-1:0] csr_wdata,
    input  logic              acc_en,
    input  logic [FLAG_W-1:0] acc_flags,
    output logic [LIVE_W-1:0] state
);
    logic [LIVE_W-1:0] nxt;
    csr_op_e           op;

    assign op = csr_op_e'(csr_op);

    // Pick the next word value: CSR modify first, then flag OR.
    always_comb begin
        nxt = state;
        if (csr_en && op != CSR_READ) begin
            case (op)
                CSR_WRITE: nxt = csr_wdata;
                CSR_SET:   nxt = state | csr_wdata;
                CSR_CLEAR: nxt = state & ~csr_wdata;
                default:   nxt = state;
            endcase
        end else if (acc_en) begin
            nxt = state | {{(LIVE_W-FLAG_W){1'b0}}, acc_flags};
        end
    end

    // Register the word with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= '0;
        else        state <= nxt;
    end
endmodule

// File: rtl/fpctl_rm_resolve.sv
// Chooses static or dynamic rounding mode and flags a reserved dynamic value.
// Assumes values 101..111 are reserved in the stored field.
module fpctl_rm_resolve
    import fpctl_pkg::*;
(
    input  logic [RM_W-1:0] op_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] eff_rm,
    output logic            rm_bad
);
    logic use_dyn;

    // Resolve the mode and test the stored value only when it is used.
    always_comb begin
        use_dyn = (op_rm == RM_DYNAMIC);
        eff_rm  = use_dyn ? dyn_rm : op_rm;
        rm_bad  = use_dyn && (dyn_rm >= 3'b101);
    end
endmodule

// File: rtl/fpctl_acc_check.sv
// Looks up the current accuracy mode in the support mask of an op class.
// Assumes SUPPORT packs one MODES-bit mask per class, class 0 lowest;
// bit 0 of every mask is forced on. Out-of-range classes support mode 0 only.
module fpctl_acc_check
    import fpctl_pkg::*;
#(
    parameter int NUM_CLASSES = 4,
    parameter logic [NUM_CLASSES*MODES-1:0] SUPPORT = '1,
    localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic [CLS_W-1:0] op_class,
    input  logic [ACC_W-1:0] acc_mode,
    output logic             unsupported
);
    logic [NUM_CLASSES-1:0] sup_by_class;

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
        localparam logic [MODES-1:0] MASK =
            SUPPORT[g*MODES +: MODES] | {{(MODES-1){1'b0}}, 1'b1};
        assign sup_by_class[g] = MASK[acc_mode];
    end

    // Select the class result; unknown classes allow only the default mode.
    always_comb begin
        if (int'(op_class) < NUM_CLASSES) unsupported = !sup_by_class[op_class];
        else                              unsupported = (acc_mode != '0);
    end
endmodule

// File: rtl/fpu_ctl_status.sv
// FP control and status word with per-operation mode resolution.
// Assumes op_flags arrive with op_valid for the issuing operation.
module fpu_ctl_status
    import fpctl_pkg::*;
#(
    parameter int NUM_CLASSES = 4,
    parameter logic [NUM_CLASSES*MODES-1:0] ACC_SUPPORT = 16'h153F,
    localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_en,
    input  logic [1:0]        csr_op,
    input  logic [WORD_W-1:0] csr_wdata,
    output logic [WORD_W-1:0] csr_rdata,
    input  logic              op_valid,
    input  logic [CLS_W-1:0]  op_class,
    input  logic [RM_W-1:0]   op_rm,
    input  logic [FLAG_W-1:0] op_flags,
    output logic [RM_W-1:0]   eff_rm,
    output logic [ACC_W-1:0]  eff_acc,
    output logic              op_illegal
);
    logic [LIVE_W-1:0] state;
    logic              rm_bad;
    logic              acc_unsup;
    logic              acc_en;

    fpctl_state_reg u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_en    (csr_en),
        .csr_op    (csr_op),
        .csr_wdata (csr_wdata[LIVE_W-1:0]),
        .acc_en    (acc_en),
        .acc_flags (op_flags),
        .state     (state)
    );

    fpctl_rm_resolve u_rm (
        .op_rm  (op_rm),
        .dyn_rm (state[RM_LSB +: RM_W]),
        .eff_rm (eff_rm),
        .rm_bad (rm_bad)
    );

    fpctl_acc_check #(
        .NUM_CLASSES (NUM_CLASSES),
        .SUPPORT     (ACC_SUPPORT)
    ) u_acc (
        .op_class    (op_class),
        .acc_mode    (state[ACC_LSB +: ACC_W]),
        .unsupported (acc_unsup)
    );

    // Combine trap causes and gate flag accumulation on a legal issue.
    always_comb begin
        op_illegal = op_valid && (rm_bad || acc_unsup);
        acc_en     = op_valid && !op_illegal;
        eff_acc    = state[ACC_LSB +: ACC_W];
        csr_rdata  = {{(WORD_W-LIVE_W){1'b0}}, state};
    end
endmodule

// File: rtl/fpctl_checker.sv
// Temporal checks on the control word ports; bound into fpu_ctl_status.
module fpctl_checker
    import fpctl_pkg::*;
#(
    parameter int CLS_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_en,
    input logic [1:0]        csr_op,
    input logic [WORD_W-1:0] csr_wdata,
    input logic [WORD_W-1:0] csr_rdata,
    input logic              op_valid,
    input logic [CLS_W-1:0]  op_class,
    input logic [RM_W-1:0]   op_rm,
    input logic [FLAG_W-1:0] op_flags,
    input logic [RM_W-1:0]   eff_rm,
    input logic [ACC_W-1:0]  eff_acc,
    input logic              op_illegal
);
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_en && csr_op == 2'd0 |=> csr_rdata == {22'b0, $past(csr_wdata[9:0])}); // R2
    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_en && csr_op == 2'd1 |=> csr_rdata == ($past(csr_rdata) | {22'b0, $past(csr_wdata[9:0])})); // R3
    AST_DYN_RM_USED: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_rm == 3'b111 |-> eff_rm == csr_rdata[7:5]); // R4
    AST_BAD_DYN_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_rm == 3'b111 && csr_rdata[7:5] >= 3'b101 |-> op_illegal); // R5
    AST_MODE0_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && eff_acc == 2'b00 && !(op_rm == 3'b111 && csr_rdata[7:5] >= 3'b101) |-> !op_illegal); // R6
    AST_FLAGS_ACCRUE: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_en && op_valid && !op_illegal |=> csr_rdata[4:0] == ($past(csr_rdata[4:0]) | $past(op_flags))); // R7
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_en && op_valid && op_illegal |=> $stable(csr_rdata)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !op_illegal); // R10
endmodule

bind fpu_ctl_status fpctl_checker #(.CLS_W(CLS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_en     (csr_en),
    .csr_op     (csr_op),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .op_valid   (op_valid),
    .op_class   (op_class),
    .op_rm      (op_rm),
    .op_flags   (op_flags),
    .eff_rm     (eff_rm),
    .eff_acc    (eff_acc),
    .op_illegal (op_illegal)
);

// File: tb/tb_fpu_ctl_status.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_fpu_ctl_status;
    localparam logic [15:0] SUP = 16'h153F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_en = 1'b0;
    logic [1:0]  csr_op = 2'd3;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        op_valid = 1'b0;
    logic [1:0]  op_class = '0;
    logic [2:0]  op_rm = '0;
    logic [4:0]  op_flags = '0;
    logic [2:0]  eff_rm;
    logic [1:0]  eff_acc;
    logic        op_illegal;

    int checks = 0;
    int fails  = 0;

    fpu_ctl_status #(.NUM_CLASSES(4), .ACC_SUPPORT(SUP)) dut (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .op_valid(op_valid),
        .op_class(op_class), .op_rm(op_rm), .op_flags(op_flags),
        .eff_rm(eff_rm), .eff_acc(eff_acc), .op_illegal(op_illegal)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One CSR access driven at a falling edge; returns the pre-access value.
    task automatic csr(input logic [1:0] op, input logic [31:0] wd, output logic [31:0] old);
        csr_en = 1'b1; csr_op = op; csr_wdata = wd;
        #4 old = csr_rdata;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd3; csr_wdata = '0;
    endtask

    task automatic rd(output logic [31:0] v);
        csr(2'd3, 32'h0, v);
    endtask

    task automatic issue(input logic [1:0] cls, input logic [2:0] rm, input logic [4:0] fl,
                         output logic [2:0] rmo, output logic [1:0] acco, output logic ill);
        op_valid = 1'b1; op_class = cls; op_rm = rm; op_flags = fl;
        #4 rmo = eff_rm; acco = eff_acc; ill = op_illegal;
        @(negedge clk);
        op_valid = 1'b0; op_flags = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(v);
        check("R1 reset word", v, 32'h0);
    endtask

    task automatic t_write();
        logic [31:0] old, v;
        csr(2'd0, 32'hFFFF_FFFF, old);
        check("R2 old value on write", old, 32'h0);
        rd(v);
        check("R2 reserved bits zero", v, 32'h3FF);
        csr(2'd0, 32'h0000_0125, old);
        check("R2 old value second write", old, 32'h3FF);
        rd(v);
        check("R2 stored value", v, 32'h125);
    endtask

    task automatic t_setclr();
        logic [31:0] old, v;
        csr(2'd0, 32'h0, old);
        csr(2'd1, 32'h0000_0300, old);
        check("R3 set old value", old, 32'h0);
        rd(v);
        check("R3 set result", v, 32'h300);
        csr(2'd2, 32'h0000_0100, old);
        check("R3 clear old value", old, 32'h300);
        rd(v);
        check("R3 clear result", v, 32'h200);
        csr(2'd3, 32'hFFFF_FFFF, old);
        rd(v);
        check("R3 read leaves word", v, 32'h200);
    endtask

    task automatic t_rm();
        logic [31:0] old;
        logic [2:0] r; logic [1:0] a; logic ill;
        for (int d = 0; d < 5; d++) begin
            csr(2'd0, 32'(d) << 5, old);
            issue(2'd0, 3'b111, 5'd0, r, a, ill);
            check("R4 dynamic resolves to stored", {29'b0, r}, 32'(d));
            check("R4 dynamic legal", {31'b0, ill}, 32'h0);
            issue(2'd0, 3'(4 - d), 5'd0, r, a, ill);
            check("R4 static passes through", {29'b0, r}, 32'(4 - d));
        end
    endtask

    task automatic t_rm_bad();
        logic [31:0] old;
        logic [2:0] r; logic [1:0] a; logic ill;
        for (int d = 5; d < 8; d++) begin
            csr(2'd0, 32'(d) << 5, old);
            issue(2'd1, 3'b111, 5'd0, r, a, ill);
            check("R5 reserved dynamic traps", {31'b0, ill}, 32'h1);
            issue(2'd1, 3'b010, 5'd0, r, a, ill);
            check("R5 static not trapped", {31'b0, ill}, 32'h0);
            check("R5 static value used", {29'b0, r}, 32'h2);
        end
    endtask

    task automatic t_acc();
        logic [31:0] old;
        logic [2:0] r; logic [1:0] a; logic ill;
        for (int m = 0; m < 4; m++) begin
            csr(2'd0, 32'(m) << 8, old);
            for (int c = 0; c < 4; c++) begin
                logic [3:0] mask;
                mask = SUP[c*4 +: 4] | 4'b0001;
                issue(2'(c), 3'b000, 5'd0, r, a, ill);
                check("R6 accuracy mode shown", {30'b0, a}, 32'(m));
                check("R6 support lookup", {31'b0, ill}, {31'b0, !mask[m]});
            end
        end
    endtask

    task automatic t_accum();
        logic [31:0] old, v;
        logic [2:0] r; logic [1:0] a; logic ill;
        csr(2'd0, 32'h0, old);
        issue(2'd2, 3'b000, 5'b00101, r, a, ill);
        rd(v);
        check("R7 first accumulate", v, 32'h05);
        issue(2'd3, 3'b001, 5'b10001, r, a, ill);
        rd(v);
        check("R7 sticky OR", v, 32'h15);
    endtask

    task automatic t_suppress();
        logic [31:0] old, v;
        logic [2:0] r; logic [1:0] a; logic ill;
        csr(2'd0, 32'h300, old);
        issue(2'd1, 3'b000, 5'h1F, r, a, ill);
        check("R8 unsupported traps", {31'b0, ill}, 32'h1);
        rd(v);
        check("R8 flags untouched by accuracy trap", v, 32'h300);
        csr(2'd0, 32'h0C0, old);
        issue(2'd0, 3'b111, 5'h1F, r, a, ill);
        rd(v);
        check("R8 flags untouched by rounding trap", v, 32'h0C0);
    endtask

    task automatic t_priority();
        logic [31:0] old, v;
        csr(2'd0, 32'h0, old);
        csr_en = 1'b1; csr_op = 2'd0; csr_wdata = 32'h40;
        op_valid = 1'b1; op_class = 2'd0; op_rm = 3'b000; op_flags = 5'h1F;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd3; op_valid = 1'b0; op_flags = '0;
        rd(v);
        check("R9 write beats accumulate", v, 32'h40);
        csr_en = 1'b1; csr_op = 2'd1; csr_wdata = 32'h01;
        op_valid = 1'b1; op_flags = 5'h02;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd3; op_valid = 1'b0; op_flags = '0;
        rd(v);
        check("R9 set beats accumulate", v, 32'h41);
    endtask

    task automatic t_idle();
        logic [31:0] old;
        csr(2'd0, 32'h3E0, old);
        op_valid = 1'b0; op_class = 2'd3; op_rm = 3'b111;
        #4 check("R10 idle no illegal", {31'b0, op_illegal}, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_setclr();
        t_rm();
        t_rm_bad();
        t_acc();
        t_accum();
        t_suppress();
        t_priority();
        t_idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule